// File: doc/BRIEF.md
# I2C Bus Start/Stop Condition Detector

This block watches the SCL and SDA lines of an I2C bus and reports START and STOP conditions. Both lines are first brought into the core clock domain through a flop synchronizer. A condition is accepted only when SCL has been high for a minimum setup interval before the SDA edge and stays high for a minimum hold interval after it. Both intervals are counted in cycles of the I2C system clock. That clock is delivered to the block as a one-cycle enable strobe, `sys_tick`, in the core clock domain.

A control byte sets how the block works. Its low five bits are a timing setting. The setting must be even and non-zero, and an illegal value stops all detection while it is loaded. Bits 5 and 6 configure a separate SCL/SDA edge interrupt. Bit 7 is stored and exported so that a neighbouring START/STOP generator can select its longer timing. The block also keeps a bus-busy flag. The edge-interrupt request is a sticky flag. Reconfiguring the interrupt or the enable can raise this flag spuriously, so software clears it after a change.

Top module: `i2c_cond_detect`

## Requirements
- R1: A write on `ctl_wr` loads `ctl_wdata` into the control byte, and `ctl_q` shows it on the next cycle. `gen_long` always equals bit 7 of the control byte. Reset clears the byte to 0x00.
- R2: `setting_bad` is 1 whenever the timing setting (bits 4..0) is zero or odd. While it is 1, no START or STOP pulse is produced.
- R3: A START is reported as a one-cycle `start_pulse`. It needs an SDA falling edge while SCL is high, with SCL already high for at least setting/2 system-clock ticks at the edge. SDA must then stay low, and SCL high, for setting/2 further ticks. The pulse comes one core cycle after the last of those ticks.
- R4: A STOP is reported as a one-cycle `stop_pulse` under the same rule, for an SDA rising edge.
- R5: An SDA edge that arrives with fewer than setting/2 ticks of SCL-high time before it produces no pulse.
- R6: If SCL falls before the hold interval completes, no pulse is produced.
- R7: While `en` is 0, no pulse is produced and `bus_busy` is cleared on the next cycle. Detection resumes as soon as `en` returns to 1.
- R8: `bus_busy` sets on the cycle after a START pulse and clears on the cycle after a STOP pulse.
- R9: Bit 6 selects the interrupt source: 1 selects SDA and 0 selects SCL. Bit 5 selects the edge: 1 selects rising and 0 selects falling. A matching edge on the selected line, with `en` high, sets `edge_irq`, which then stays set. Edges on the other line have no effect.
- R10: `irq_clr` clears `edge_irq`, but a new set event in the same cycle wins. Changing bit 5, bit 6 or `en` so that the gated level rises sets `edge_irq`.
- R11: The setup and hold intervals advance only on cycles where `sys_tick` is 1. With no ticks, a pending condition never completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | One-cycle strobe per I2C system clock period |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| en | input | 1 | Interface enable |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| irq_clr | input | 1 | Clear the edge-interrupt request |
| ctl_q | output | 8 | Current control byte |
| gen_long | output | 1 | Long generation timing select (bit 7) |
| setting_bad | output | 1 | Timing setting is zero or odd |
| start_pulse | output | 1 | One-cycle START report |
| stop_pulse | output | 1 | One-cycle STOP report |
| bus_busy | output | 1 | Bus held between START and STOP |
| edge_irq | output | 1 | Sticky SCL/SDA edge-interrupt request |

## Verification
The properties assume that `irq_clr` is the only way to lower the interrupt request. They also assume that `en` and `ctl_wr` change only between clock edges, so a pulse and the busy flag always see the same configuration. The stimulus drives every input on the falling clock edge. It holds each bus level for many ticks, except where a short setup or an early SCL fall is the point of the test. It also toggles the enable only while the lines are steady, so each scenario gives a count of pulses that is known in advance.

// File: rtl/icd_pkg.sv
package icd_pkg;
   typedef enum logic [1:0] {
      PEND_NONE  = 2'd0,
      PEND_START = 2'd1,
      PEND_STOP  = 2'd2
   } pend_e;
endpackage

// File: rtl/icd_sync.sv
module icd_sync #(
   parameter int STAGES = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("icd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/icd_cond_timer.sv
module icd_cond_timer
   import icd_pkg::*;
#(
   parameter int SET_W = 5,
   localparam int HW = SET_W - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          active,
   input  logic          scl,
   input  logic          sda,
   input  logic [HW-1:0] half,
   output logic          start_p,
   output logic          stop_p
);
   generate
      if (SET_W < 2) begin : g_bad_width
         $error("icd_cond_timer: SET_W must be at least 2");
      end
   endgenerate

   localparam logic [SET_W-1:0] HI_MAX = '1;

   logic             sda_d;
   logic             sda_edge;
   logic             setup_ok;
   logic [SET_W-1:0] hi_cnt;
   logic [HW-1:0]    hold;
   pend_e            pend;

   assign sda_edge = sda_d ^ sda;
   assign setup_ok = scl && (hi_cnt >= {1'b0, half});

   // SCL-high time counted in system-clock ticks, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       hi_cnt <= '0;
      else if (!scl)                    hi_cnt <= '0;
      else if (tick && hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_d   <= 1'b1;
         pend    <= PEND_NONE;
         hold    <= '0;
         start_p <= 1'b0;
         stop_p  <= 1'b0;
      end else begin
         sda_d   <= sda;
         start_p <= 1'b0;
         stop_p  <= 1'b0;
         if (!active) begin
            pend <= PEND_NONE;
         end else if (sda_edge) begin
            if (setup_ok) begin
               pend <= sda ? PEND_STOP : PEND_START;
               hold <= half;
            end else begin
               pend <= PEND_NONE;
            end
         end else if (pend != PEND_NONE) begin
            if (!scl) begin
               pend <= PEND_NONE;
            end else if (tick) begin
               if (hold <= 1) begin
                  pend    <= PEND_NONE;
                  start_p <= (pend == PEND_START);
                  stop_p  <= (pend == PEND_STOP);
               end else begin
                  hold <= hold - 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/icd_edge_irq.sv
module icd_edge_irq #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pick_sda,
   input  logic on_rise,
   input  logic scl,
   input  logic sda,
   input  logic clr,
   output logic req
);
   logic src, level, level_d, set_ev;

   assign src    = pick_sda ? sda : scl;
   assign level  = en && (on_rise ? src : !src);
   assign set_ev = level && !level_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level;
   end

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      req <= 1'b0;
            else if (set_ev) req <= 1'b1;
            else if (clr)    req <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      req <= 1'b0;
            else if (clr)    req <= 1'b0;
            else if (set_ev) req <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
   parameter int SET_W        = 5,
   parameter int SYNC_STAGES  = 2,
   parameter bit IRQ_SET_WINS = 1'b1,
   localparam int CTL_W   = SET_W + 3,
   localparam int POL_BIT = SET_W,
   localparam int SEL_BIT = SET_W + 1,
   localparam int GEN_BIT = SET_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sys_tick,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic             en,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             irq_clr,
   output logic [CTL_W-1:0] ctl_q,
   output logic             gen_long,
   output logic             setting_bad,
   output logic             start_pulse,
   output logic             stop_pulse,
   output logic             bus_busy,
   output logic             edge_irq
);
   generate
      if (SET_W < 2) begin : g_bad_set_w
         $error("i2c_cond_detect: SET_W must be at least 2");
      end
   endgenerate

   logic             scl_s, sda_s;
   logic [SET_W-1:0] setting;
   logic             active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctl_wdata;
   end

   assign setting     = ctl_q[SET_W-1:0];
   assign setting_bad = (setting == '0) || setting[0];
   assign gen_long    = ctl_q[GEN_BIT];
   assign active      = en && !setting_bad;

   icd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
   );
   icd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   icd_cond_timer #(.SET_W(SET_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(sys_tick), .active(active),
      .scl(scl_s), .sda(sda_s), .half(setting[SET_W-1:1]),
      .start_p(start_pulse), .stop_p(stop_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           bus_busy <= 1'b0;
      else if (!en)         bus_busy <= 1'b0;
      else if (start_pulse) bus_busy <= 1'b1;
      else if (stop_pulse)  bus_busy <= 1'b0;
   end

   icd_edge_irq #(.SET_WINS(IRQ_SET_WINS)) u_irq (
      .clk(clk), .rst_n(rst_n), .en(en),
      .pick_sda(ctl_q[SEL_BIT]), .on_rise(ctl_q[POL_BIT]),
      .scl(scl_s), .sda(sda_s), .clr(irq_clr), .req(edge_irq)
   );
endmodule

// File: rtl/icd_checker.sv
module icd_checker (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic irq_clr,
   input logic setting_bad,
   input logic start_pulse,
   input logic stop_pulse,
   input logic bus_busy,
   input logic edge_irq
);
   p_not_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_pulse && stop_pulse));

   p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

   p_stop_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |=> !stop_pulse);

   p_bad_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      setting_bad |=> !(start_pulse || stop_pulse));

   p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !(start_pulse || stop_pulse) && !bus_busy);

   p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_busy) |-> $past(start_pulse));

   p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_busy) |-> ($past(stop_pulse) || !$past(en)));

   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_irq && !irq_clr) |=> edge_irq);

   p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(edge_irq) |-> $past(irq_clr));
endmodule

bind i2c_cond_detect icd_checker u_icd_checker (
   .clk(clk), .rst_n(rst_n), .en(en), .irq_clr(irq_clr),
   .setting_bad(setting_bad), .start_pulse(start_pulse),
   .stop_pulse(stop_pulse), .bus_busy(bus_busy), .edge_irq(edge_irq)
);

// File: tb/i2c_cond_detect_bench.sv
`timescale 1ns/1ps
module i2c_cond_detect_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sys_tick = 1'b0;
   logic       scl_in = 1'b1, sda_in = 1'b1, en = 1'b0;
   logic       ctl_wr = 1'b0, irq_clr = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] ctl_q;
   logic       gen_long, setting_bad, start_pulse, stop_pulse, bus_busy, edge_irq;

   always #10 clk = ~clk;

   i2c_cond_detect u_i2c_cond_detect (
      .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .scl_in(scl_in),
      .sda_in(sda_in), .en(en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .irq_clr(irq_clr), .ctl_q(ctl_q), .gen_long(gen_long),
      .setting_bad(setting_bad), .start_pulse(start_pulse),
      .stop_pulse(stop_pulse), .bus_busy(bus_busy), .edge_irq(edge_irq)
   );

   int  vectors = 0, miscompares = 0;
   int  starts_seen = 0, stops_seen = 0;
   bit  done = 1'b0;
   bit  tick_on = 1'b1;

   task automatic chk(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int   m_c1, m_c2, m_d1, m_d2, m_dd;
   int   m_hi, m_pend, m_hold;
   bit   m_start, m_stop, m_busy, m_lvl, m_irq;
   logic [7:0] m_ctl;
   int   t_set, t_half, t_hi, t_pend, t_hold, t_src;
   bit   t_act, t_edge, t_start, t_stop, t_busy, t_lvl, t_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_c1 = 1; m_c2 = 1; m_d1 = 1; m_d2 = 1; m_dd = 1;
         m_hi = 0; m_pend = 0; m_hold = 0;
         m_start = 0; m_stop = 0; m_busy = 0; m_lvl = 0; m_irq = 0;
         m_ctl = 8'h00;
      end else begin
         t_set  = int'(m_ctl[4:0]);
         t_half = t_set / 2;
         t_act  = en && t_set != 0 && (t_set % 2) == 0;
         t_edge = (m_dd != m_d2);
         t_start = 0; t_stop = 0; t_pend = m_pend; t_hold = m_hold;
         if (m_c2 == 0) t_hi = 0;
         else if (sys_tick && m_hi < 31) t_hi = m_hi + 1;
         else t_hi = m_hi;
         if (!t_act) t_pend = 0;
         else if (t_edge) begin
            if (m_c2 == 1 && m_hi >= t_half) begin
               t_pend = (m_d2 == 1) ? 2 : 1;
               t_hold = t_half;
            end else t_pend = 0;
         end else if (m_pend != 0) begin
            if (m_c2 == 0) t_pend = 0;
            else if (sys_tick) begin
               if (m_hold <= 1) begin
                  t_pend = 0;
                  t_start = (m_pend == 1);
                  t_stop  = (m_pend == 2);
               end else t_hold = m_hold - 1;
            end
         end
         if (!en) t_busy = 0;
         else if (m_start) t_busy = 1;
         else if (m_stop) t_busy = 0;
         else t_busy = m_busy;
         t_src = m_ctl[6] ? m_d2 : m_c2;
         t_lvl = en && (m_ctl[5] ? (t_src == 1) : (t_src == 0));
         if (t_lvl && !m_lvl) t_irq = 1;
         else if (irq_clr) t_irq = 0;
         else t_irq = m_irq;
         if (ctl_wr) m_ctl = ctl_wdata;
         m_dd = m_d2; m_d2 = m_d1; m_d1 = int'(sda_in);
         m_c2 = m_c1; m_c1 = int'(scl_in);
         m_hi = t_hi; m_pend = t_pend; m_hold = t_hold;
         m_start = t_start; m_stop = t_stop; m_busy = t_busy;
         m_lvl = t_lvl; m_irq = t_irq;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 ctl_q", int'(ctl_q), int'(m_ctl));
         chk("R1 gen_long", int'(gen_long), int'(m_ctl[7]));
         chk("R2 setting_bad", int'(setting_bad),
             int'(m_ctl[4:0] == 5'd0 || m_ctl[0]));
         chk("R3 start_pulse", int'(start_pulse), int'(m_start));
         chk("R4 stop_pulse", int'(stop_pulse), int'(m_stop));
         chk("R8 bus_busy", int'(bus_busy), int'(m_busy));
         chk("R9 edge_irq", int'(edge_irq), int'(m_irq));
         if (start_pulse) starts_seen++;
         if (stop_pulse)  stops_seen++;
      end
   end

   // ---------------- stimulus ----------------
   task automatic wcyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_ctl(logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      wcyc(1);
      ctl_wr = 1'b0;
      wcyc(1);
   endtask

   task automatic pulse_clr();
      irq_clr = 1'b1; wcyc(1); irq_clr = 1'b0; wcyc(3);
   endtask

   task automatic do_start();
      scl_in = 1'b0; wcyc(4);
      sda_in = 1'b1; wcyc(4);
      scl_in = 1'b1; wcyc(40);
      sda_in = 1'b0; wcyc(40);
   endtask

   task automatic do_stop();
      scl_in = 1'b0; wcyc(8);
      sda_in = 1'b0; wcyc(8);
      scl_in = 1'b1; wcyc(40);
      sda_in = 1'b1; wcyc(40);
   endtask

   initial begin
      forever begin
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            sys_tick = tick_on && (k == 3);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   int c0, s0;
   initial begin
      wcyc(5);
      rst_n = 1'b1;
      wcyc(2);
      chk("R1 reset ctl", int'(ctl_q), 0);
      chk("R2 reset bad", int'(setting_bad), 1);
      chk("R8 reset busy", int'(bus_busy), 0);

      write_ctl(8'h88);
      chk("R1 ctl write", int'(ctl_q), 8'h88);
      chk("R1 gen bit", int'(gen_long), 1);
      chk("R2 legal", int'(setting_bad), 0);

      en = 1'b1; wcyc(10);
      c0 = starts_seen; do_start();
      chk("R3 start count", starts_seen - c0, 1);
      chk("R8 busy set", int'(bus_busy), 1);
      s0 = stops_seen; do_stop();
      chk("R4 stop count", stops_seen - s0, 1);
      chk("R8 busy clear", int'(bus_busy), 0);

      // R5: too little setup
      scl_in = 1'b0; wcyc(8); sda_in = 1'b1; wcyc(8);
      c0 = starts_seen;
      scl_in = 1'b1; wcyc(2); sda_in = 1'b0; wcyc(40);
      chk("R5 short setup", starts_seen - c0, 0);
      scl_in = 1'b0; wcyc(8); sda_in = 1'b1; wcyc(8);

      // R6: SCL falls inside hold
      c0 = starts_seen;
      scl_in = 1'b1; wcyc(40); sda_in = 1'b0; wcyc(6); scl_in = 1'b0; wcyc(20);
      chk("R6 early scl fall", starts_seen - c0, 0);
      sda_in = 1'b1; wcyc(8);

      // R11: no ticks, no completion
      c0 = starts_seen;
      scl_in = 1'b1; wcyc(40); tick_on = 1'b0; sda_in = 1'b0; wcyc(60);
      chk("R11 no ticks", starts_seen - c0, 0);
      tick_on = 1'b1; wcyc(40);
      chk("R11 ticks resume", starts_seen - c0, 1);
      do_stop();

      // R2: odd setting blocks detection
      write_ctl(8'h07);
      chk("R2 odd bad", int'(setting_bad), 1);
      c0 = starts_seen; do_start();
      chk("R2 no start", starts_seen - c0, 0);
      do_stop();

      // R7: disable
      write_ctl(8'h08);
      chk("R1 gen clear", int'(gen_long), 0);
      c0 = starts_seen; do_start();
      chk("R7 start before off", starts_seen - c0, 1);
      en = 1'b0; wcyc(4);
      chk("R7 busy off", int'(bus_busy), 0);
      do_stop();
      c0 = starts_seen; do_start();
      chk("R7 no start off", starts_seen - c0, 0);

      // R9: SCL falling
      en = 1'b1; scl_in = 1'b1; wcyc(8);
      pulse_clr();
      chk("R9 irq idle", int'(edge_irq), 0);
      scl_in = 1'b0; wcyc(8);
      chk("R9 scl fall irq", int'(edge_irq), 1);
      wcyc(10);
      chk("R9 sticky", int'(edge_irq), 1);
      pulse_clr();
      wcyc(16);
      chk("R10 cleared", int'(edge_irq), 0);

      // R9: SDA rising, SCL ignored
      sda_in = 1'b0; wcyc(8);
      write_ctl(8'h68); wcyc(4);
      pulse_clr();
      scl_in = 1'b1; wcyc(8); scl_in = 1'b0; wcyc(8);
      chk("R9 scl ignored", int'(edge_irq), 0);
      sda_in = 1'b1; wcyc(8);
      chk("R9 sda rise irq", int'(edge_irq), 1);

      // R10: reconfiguration raises request
      pulse_clr();
      chk("R10 clr", int'(edge_irq), 0);
      en = 1'b0; wcyc(4);
      en = 1'b1; wcyc(4);
      chk("R10 reenable irq", int'(edge_irq), 1);

      wcyc(4);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule